// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for an 8-channel, 12-bit successive-approximation converter with a four-wire serial port. The system side raises a one-cycle request with a channel number, a bipolar flag, a range flag and a clock-mode choice. The block then lowers chip select and shifts out an 8-bit command word. It generates the serial clock from a programmable half-period divider and collects the 12-bit conversion result, which it returns with a one-cycle valid pulse.

There are two ways to finish a conversion. In internal-clock mode the converter times its own conversion. The master parks the serial clock low until the converter's end-of-conversion strobe rises, then clocks the result out. In external-clock mode the master supplies a fixed 18-clock frame after the command word. The result bits arrive during the last 12 clocks of that frame. A timeout guards the internal-clock wait so that a silent converter cannot hang the master.

Top module: `adc_host`

## Requirements
- R1: The command word goes out MSB first as {1, ch[2:0], bip, rng, m1, m0}. The bits m1,m0 are 2'b11 when ext_i=1 (external clock) and 2'b00 when ext_i=0 (internal clock).
- R2: The serial clock idles low. din_o changes only while sclk_o is low, and dout_i is sampled at the rising sclk_o edges.
- R3: Each high and low phase of sclk_o lasts half_i+1 system clocks, using the half_i value captured when the request is accepted.
- R4: In internal-clock mode, 8 clocks carry the command. sclk_o then stays low while sstrb_i is low and until sstrb_i rises. After the rise, exactly 12 more clocks are issued, and their rising edges sample D11 down to D0 (20 rising edges in total).
- R5: In external-clock mode, 18 clocks follow the 8 command clocks. Only the rising edges of clocks 7 to 18 of that 18-clock run are sampled, as D11 down to D0 (26 rising edges in total).
- R6: The result appears on data_o with D11 in bit 11 and D0 in bit 0, together with a single-cycle valid_o. In that same cycle cs_no returns high and busy_o falls. Bits the converter would send after D0 are never clocked in.
- R7: If sstrb_i does not rise within timeout_i+1 system clocks of the end of the command word, the frame is abandoned. err_o pulses for one cycle, cs_no returns high and no valid_o is produced.
- R8: A request is accepted only while busy_o is low. A request raised while busy_o is high has no effect on the running frame and starts no new one.
- R9: After reset, cs_no is high, sclk_o is low, and busy_o, valid_o and err_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Conversion request, taken when busy_o is low |
| ch_i | input | 3 | Channel number |
| bip_i | input | 1 | Bipolar input range select |
| rng_i | input | 1 | Full-scale range select |
| ext_i | input | 1 | 1: master-clocked 18-clock frame; 0: converter-timed with strobe wait |
| half_i | input | DIV_W | Serial clock half period minus one, in system clocks |
| timeout_i | input | TO_W | Strobe wait limit minus one, in system clocks |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle pulse, data_o is valid |
| data_o | output | 12 | Conversion result |
| err_o | output | 1 | One-cycle pulse on strobe timeout |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to converter |
| din_o | output | 1 | Serial command data to converter |
| dout_i | input | 1 | Serial result data from converter |
| sstrb_i | input | 1 | Converter end-of-conversion strobe |

## Verification
The assertions check the pin rules on every cycle. While idle, chip select is high and the clock low. Command data holds steady through each high phase. The clock never rises while chip select is low and the strobe is low. Results and timeouts come as exclusive single-cycle pulses, and a request seen while idle always starts a frame. Only the bench scenarios show the content of a frame: the command bits, the number of clock edges for each mode, the clock phase width for several divider settings, the position of the result bits (with trailing zeros offered after D0), the timeout path and recovery from it, and that a request made during a frame is dropped.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int RES_W    = 12;
  localparam int CMD_W    = 8;
  localparam int CH_W     = 3;
  localparam int EXT_CLKS = 18;
  localparam int CNT_W    = $clog2(EXT_CLKS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_READ
  } state_e;

  // start bit, channel, bip, rng, two mode bits (11 ext clock, 00 internal)
  function automatic logic [CMD_W-1:0] make_cmd(logic [CH_W-1:0] ch, logic bip,
                                                logic rng, logic ext);
    return {1'b1, ch, bip, rng, ext, ext};
  endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             tick;

  assign tick   = en_i && (cnt_q == half_i);
  // edge about to happen at the coming clk_i edge
  assign rise_o = tick && !sclk_o;
  assign fall_o = tick && sclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_o <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_o <= !sclk_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q[i] <= RST_VAL;
      else if (i == 0) r_q[i] <= d_i;
      else r_q[i] <= r_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/adc_shreg.sv
module adc_shreg #(
  parameter int CMD_W = 8,
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             shift_out_i,
  input  logic             shift_in_i,
  input  logic             bit_i,
  output logic             din_o,
  output logic [RES_W-1:0] res_o
);
  logic [CMD_W-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
      res_o <= '0;
    end else begin
      if (load_i) cmd_q <= cmd_i;
      else if (shift_out_i) cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
      if (load_i) res_o <= '0;
      else if (shift_in_i) res_o <= {res_o[RES_W-2:0], bit_i};
    end
  end

  assign din_o = cmd_q[CMD_W-1];
endmodule

// File: rtl/adc_host.sv
module adc_host
  import adc_host_pkg::*;
#(
  parameter int DIV_W       = 8,
  parameter int TO_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2:0]       ch_i,
  input  logic             bip_i,
  input  logic             rng_i,
  input  logic             ext_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [TO_W-1:0]  timeout_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [11:0]      data_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  input  logic             sstrb_i
);
  localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_EXT = CNT_W'(EXT_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_INT = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] SKIP_EXT = CNT_W'(EXT_CLKS - RES_W);

  state_e           state_q;
  logic [CNT_W-1:0] bcnt_q;
  logic [TO_W-1:0]  to_q;
  logic [DIV_W-1:0] half_q;
  logic             ext_q, strb_prev_q;
  logic             strb_s, strb_rise;
  logic             sclk_en, rise, fall, start;
  logic             shift_out, shift_in;
  logic [RES_W-1:0] res;
  logic [CNT_W-1:0] last_clk, first_smp;

  assign start     = (state_q == ST_IDLE) && req_i;
  assign sclk_en   = (state_q == ST_CMD) || (state_q == ST_READ);
  assign strb_rise = strb_s && !strb_prev_q;
  assign last_clk  = ext_q ? LAST_EXT : LAST_INT;
  assign first_smp = ext_q ? SKIP_EXT : '0;
  assign shift_out = (state_q == ST_CMD) && fall;
  assign shift_in  = (state_q == ST_READ) && rise && (bcnt_q >= first_smp);
  assign busy_o    = (state_q != ST_IDLE);

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i, .rst_ni, .en_i(sclk_en), .half_i(half_q),
    .sclk_o, .rise_o(rise), .fall_o(fall)
  );

  adc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(sstrb_i), .q_o(strb_s)
  );

  adc_shreg #(.CMD_W(CMD_W), .RES_W(RES_W)) u_sh (
    .clk_i, .rst_ni, .load_i(start), .cmd_i(make_cmd(ch_i, bip_i, rng_i, ext_i)),
    .shift_out_i(shift_out), .shift_in_i(shift_in), .bit_i(dout_i),
    .din_o, .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bcnt_q      <= '0;
      to_q        <= '0;
      half_q      <= '0;
      ext_q       <= 1'b0;
      strb_prev_q <= 1'b1;
      cs_no       <= 1'b1;
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      data_o      <= '0;
    end else begin
      valid_o     <= 1'b0;
      err_o       <= 1'b0;
      strb_prev_q <= strb_s;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_CMD;
          cs_no   <= 1'b0;
          bcnt_q  <= '0;
          ext_q   <= ext_i;
          half_q  <= half_i;
        end
        ST_CMD: if (fall) begin
          if (bcnt_q == LAST_CMD) begin
            bcnt_q  <= '0;
            to_q    <= '0;
            state_q <= ext_q ? ST_READ : ST_WAIT;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (strb_rise) begin
            state_q <= ST_READ;
          end else if (to_q == timeout_i) begin
            state_q <= ST_IDLE;
            cs_no   <= 1'b1;
            err_o   <= 1'b1;
          end else begin
            to_q <= to_q + 1'b1;
          end
        end
        ST_READ: if (fall) begin
          if (bcnt_q == last_clk) begin
            state_q <= ST_IDLE;
            cs_no   <= 1'b1;
            valid_o <= 1'b1;
            data_o  <= res;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic busy_o,
  input logic valid_o,
  input logic err_o,
  input logic cs_no,
  input logic sclk_o,
  input logic din_o,
  input logic sstrb_i
);
  // R9
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o));

  // R2
  din_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(din_o));

  // R4
  strobe_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !sstrb_i) |-> !sclk_o);

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R6
  valid_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(busy_o) && cs_no));

  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!valid_o && cs_no));

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

bind adc_host adc_host_chk u_chk (.*);

// File: tb/sim_adc_host.sv
module sim_adc_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  ch = '0;
  logic        bip = 1'b0, rng = 1'b0, ext = 1'b0;
  logic [7:0]  half = '0;
  logic [15:0] timeout = 16'd200;
  logic        busy, valid, err, cs_n, sclk, din, dout;
  logic        sstrb = 1'b1;
  logic [11:0] data;

  always #2 clk = !clk;

  adc_host u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ch_i(ch), .bip_i(bip), .rng_i(rng),
    .ext_i(ext), .half_i(half), .timeout_i(timeout), .busy_o(busy), .valid_o(valid),
    .data_o(data), .err_o(err), .cs_no(cs_n), .sclk_o(sclk), .din_o(din),
    .dout_i(dout), .sstrb_i(sstrb)
  );

  typedef struct {
    logic [7:0]  cmd;
    logic [11:0] data;
    bit          is_err;
    int          rises;
    int          width;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // converter model
  logic [7:0]  m_cmd;
  logic [11:0] m_sh, m_result;
  int          m_rise, m_fall, m_viol;
  bit          m_silent;
  assign dout = m_sh[11];

  always @(negedge cs_n) begin
    m_cmd = '0; m_rise = 0; m_fall = 0; m_viol = 0; m_sh = '0;
  end
  always @(posedge cs_n) sstrb = 1'b1;

  always @(posedge sclk) if (!cs_n) begin
    m_rise++;
    if (!sstrb) m_viol++;
    if (m_rise <= 8) m_cmd = {m_cmd[6:0], din};
  end

  always @(negedge sclk) if (!cs_n) begin
    m_fall++;
    if (m_fall == 8 && m_cmd[1:0] == 2'b00) begin
      sstrb = 1'b0;
      if (!m_silent) begin
        repeat (30) @(posedge clk);
        #1;
        m_sh  = m_result;
        sstrb = 1'b1;
      end
    end else if (m_cmd[1:0] == 2'b11 && m_fall == 14) begin
      m_sh = m_result;
    end else if (m_fall > 8) begin
      m_sh = m_sh << 1;
    end
  end

  // phase width of sclk high
  int hcnt = 0, last_hi = 0;
  always @(negedge clk) begin
    if (sclk) hcnt++;
    else if (hcnt != 0) begin last_hi = hcnt; hcnt = 0; end
  end

  // monitor
  always @(negedge clk) if (rst_n && (valid || err)) begin
    exp_t e;
    if (q.size() == 0) begin
      chk(0, "R8 unexpected completion", 1, 0);
    end else begin
      e = q.pop_front();
      chk(err == e.is_err, "R7 completion kind", err, e.is_err);
      chk(m_cmd == e.cmd, "R1 command word", m_cmd, e.cmd);
      chk(m_rise == e.rises, "R4/R5 rising edge count", m_rise, e.rises);
      chk(last_hi == e.width, "R3 sclk phase width", last_hi, e.width);
      chk(m_viol == 0, "R4 sclk rose during strobe low", m_viol, 0);
      chk(cs_n == 1'b1 && busy == 1'b0, "R6 frame closed", {cs_n, busy}, 2'b10);
      if (!e.is_err) chk(data == e.data, "R6 result data", data, e.data);
    end
  end

  task automatic xfer(input logic [2:0] c, input logic b, input logic r, input logic x,
                      input logic [7:0] h, input logic [11:0] res, input bit silent,
                      input bit poke);
    exp_t e;
    @(negedge clk);
    m_result = res; m_silent = silent;
    ch = c; bip = b; rng = r; ext = x; half = h;
    e.cmd    = {1'b1, c, b, r, x, x};
    e.data   = res;
    e.is_err = silent;
    e.rises  = silent ? 8 : (x ? 26 : 20);
    e.width  = h + 1;
    q.push_back(e);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin
      repeat (20) @(negedge clk);
      ch = ~c; ext = !x; half = h + 3; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      chk(busy == 1'b1, "R8 busy during ignored request", busy, 1);
    end
    while (!(valid || err)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(cs_n == 1'b1, "R9 cs_no after reset", cs_n, 1);
    chk(sclk == 1'b0, "R9 sclk_o after reset", sclk, 0);
    chk({busy, valid, err} == 3'b000, "R9 status after reset", {busy, valid, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    xfer(3'd5, 1'b1, 1'b0, 1'b0, 8'd1, 12'hA5C, 0, 0);  // R4 internal
    xfer(3'd2, 1'b0, 1'b1, 1'b1, 8'd0, 12'h801, 0, 0);  // R5 external
    xfer(3'd7, 1'b1, 1'b1, 1'b1, 8'd3, 12'hFFF, 0, 0);  // R5, R3 slower clock
    xfer(3'd0, 1'b0, 1'b0, 1'b0, 8'd2, 12'h001, 0, 0);  // R6 LSB, zeros after D0
    xfer(3'd3, 1'b0, 1'b1, 1'b0, 8'd0, 12'h3C5, 0, 0);  // R4 fastest clock
    xfer(3'd4, 1'b1, 1'b0, 1'b0, 8'd1, 12'h123, 1, 0);  // R7 timeout
    chk(cs_n == 1'b1 && !busy, "R7 idle after timeout", {cs_n, busy}, 2'b10);
    xfer(3'd6, 1'b0, 1'b0, 1'b0, 8'd1, 12'h7E4, 0, 0);  // recovery after R7
    xfer(3'd1, 1'b1, 1'b0, 1'b1, 8'd1, 12'h5A3, 0, 1);  // R8 request while busy
    repeat (200) @(negedge clk);
    chk(q.size() == 0, "R8 pending completions", q.size(), 0);
    chk(!busy && cs_n, "R8 no extra frame started", {busy, cs_n}, 2'b01);
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end
endmodule